// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A cycle-level model of a pipelined burst SRAM. It has a chip-select front end, two competing address strobes, a 2-bit burst counter and a small byte-lane array behind them. On every rising clock edge the block samples its control and address inputs. An accepted strobe opens an access at a new address. Later cycles either hold that address or step it through a four-beat burst, in linear or interleaved order as the `mode_i` strap selects.

Each access is either a read or a byte-lane write. Read data leaves through a one-stage output register, one cycle after its address was taken. An asynchronous active-low output enable gates the data drivers. That enable is held off for the first data beat after the part comes out of a deselected state. The sleep input freezes every state register and the array until it is released.

The bidirectional data bus is split into an input port, an output port and a drive-enable port. The pads sit outside the block.

Top module: `burst_sram`

## Requirements
- R1: The part is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. An accepted strobe while not selected ends any burst, performs no access, and leaves `dq_oe_o` low in the following cycle.
- R2: `adsp_ni` is ignored while `ce1_ni`=1. A burst in progress then continues as if no strobe had been given, and the new `addr_i` is not used.
- R3: When `adsp_ni` and `adsc_ni` are both low in one cycle, only the processor strobe is taken. A cycle opened by the processor strobe is always a read and writes no lane, whatever `bwe_ni` and `bw_ni` are.
- R4: An accepted, selected strobe captures the whole of `addr_i` and loads `addr_i[1:0]` as the burst start. The access in that cycle uses `addr_i`, and `adv_ni` is not looked at in that cycle.
- R5: With `mode_i`=0 the low address bits follow start+k modulo 4. The burst step k goes up by one in each burst cycle without a strobe in which `adv_ni`=0.
- R6: With `mode_i`=1 the low address bits are start XOR k. The step k advances under the same rule as in R5.
- R7: In a burst cycle without a strobe, `adv_ni`=1 keeps the address of the previous access.
- R8: A cycle writes lane i (bits 8i+7..8i) when it is an access and `bwe_ni`=0 and `bw_ni[i]`=0. A cycle that writes at least one lane drives no data next cycle. With `bwe_ni`=1 the cycle is a read and the array is unchanged.
- R9: A read's data appears on `dq_o` in the cycle after the edge at which its address was used. After reset `dq_oe_o`=0.
- R10: `dq_oe_o` is low at once, without waiting for a clock, whenever `oe_ni`=1.
- R11: The read beat that follows a cycle in which no burst was active (deselected or just out of reset) is not driven. Its `dq_oe_o` is 0.
- R12: While `zz_i`=1 there is no access and no change of address or burst state. `dq_oe_o` is 0 in the cycle after each sleep cycle. Array contents survive the sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce1_ni | input | 1 | Chip enable 1, active low; also qualifies the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| adsp_ni | input | 1 | Processor address strobe, active low, higher priority |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | BYTES | Per-lane write strobes, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| mode_i | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| zz_i | input | 1 | Sleep, active high |
| dq_i | input | BYTES*BYTE_W | Write data |
| dq_o | output | BYTES*BYTE_W | Read data |
| dq_oe_o | output | 1 | Data drive enable |

## Verification
Two functions can fall in the same cycle: a processor strobe and a byte-write request. The bench provokes this by pulling both strobes low with `bwe_ni` and every `bw_ni` low and junk on `dq_i`. It then reads the word back and requires the old contents, because the read must win and no lane may be written. A second overlap is sleep meeting a write strobe; the bench judges it the same way, by reading the word back after the sleep ends. Random stimulus also mixes strobes, advances, deselects and sleep cycles in both burst orders. Every cycle it is compared with a cycle model built from the requirements.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  function automatic logic [1:0] burst_seq(logic [1:0] start, logic [1:0] step, logic ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode (
  input  logic ce1_ni,
  input  logic ce2_i,
  input  logic ce3_ni,
  input  logic adsp_ni,
  input  logic adsc_ni,
  input  logic zz_i,
  output logic sel_o,
  output logic proc_o,
  output logic strobe_o
);
  logic ctrl;
  assign sel_o    = !ce1_ni && ce2_i && !ce3_ni;
  // processor strobe needs ce1 and beats the controller strobe
  assign proc_o   = !zz_i && !adsp_ni && !ce1_ni;
  assign ctrl     = !zz_i && !adsc_ni && !proc_o;
  assign strobe_o = proc_o || ctrl;
endmodule

// File: rtl/bsr_burst.sv
module bsr_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic              adv_i,
  input  logic              hold_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              active_o,
  output logic [1:0]        step_o
);
  import burst_sram_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      start_q, step_q, step_nxt;
  logic            active_q;

  assign step_nxt   = step_q + {1'b0, adv_i};
  assign cur_addr_o = load_i ? addr_i : {base_q, burst_seq(start_q, step_nxt, mode_i)};
  assign active_o   = active_q;
  assign step_o     = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      start_q  <= '0;
      step_q   <= '0;
      active_q <= 1'b0;
    end else if (!hold_i) begin
      if (load_i) begin
        base_q   <= addr_i[ADDR_W-1:2];
        start_q  <= addr_i[1:0];
        step_q   <= '0;
        active_q <= 1'b1;
      end else if (stop_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        step_q <= step_nxt;
      end
    end
  end
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [BYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i && we_i[g]) mem_q[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    // read-before-write on the output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (en_i) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = rd_q;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic                    bwe_ni,
  input  logic [BYTES-1:0]        bw_ni,
  input  logic                    oe_ni,
  input  logic                    mode_i,
  input  logic                    zz_i,
  input  logic [BYTES*BYTE_W-1:0] dq_i,
  output logic [BYTES*BYTE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  logic              sel, proc, strobe, active;
  logic [1:0]        step;
  logic [ADDR_W-1:0] cur_addr;
  logic              access, wr_ok, rd_cyc;
  logic [BYTES-1:0]  lane_we;
  logic              rd_vld_q, mask_q;

  bsr_decode u_decode (
    .ce1_ni, .ce2_i, .ce3_ni, .adsp_ni, .adsc_ni, .zz_i,
    .sel_o(sel), .proc_o(proc), .strobe_o(strobe)
  );

  bsr_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i, .rst_ni, .addr_i,
    .load_i(strobe && sel), .stop_i(strobe && !sel),
    .adv_i(!adv_ni), .hold_i(zz_i), .mode_i,
    .cur_addr_o(cur_addr), .active_o(active), .step_o(step)
  );

  assign access  = !zz_i && (strobe ? sel : active);
  assign wr_ok   = access && !proc && !bwe_ni;
  assign lane_we = {BYTES{wr_ok}} & ~bw_ni;
  assign rd_cyc  = access && (lane_we == '0);

  bsr_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i, .rst_ni, .en_i(access), .we_i(lane_we),
    .addr_i(cur_addr), .wdata_i(dq_i), .rdata_o(dq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      rd_vld_q <= rd_cyc;
      mask_q   <= rd_cyc && !active;  // first beat out of deselect
    end
  end

  assign dq_oe_o = rd_vld_q && !mask_q && !oe_ni;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce1_ni,
  input logic       ce2_i,
  input logic       ce3_ni,
  input logic       adsp_ni,
  input logic       adsc_ni,
  input logic       adv_ni,
  input logic       oe_ni,
  input logic       zz_i,
  input logic       dq_oe_o,
  input logic       active_i,
  input logic [1:0] step_i
);
  logic sel_c, strb_c;
  assign sel_c  = !ce1_ni && ce2_i && !ce3_ni;
  assign strb_c = !zz_i && ((!adsp_ni && !ce1_ni) || !adsc_ni);

  AST_OE_HIGH_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R10
  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |=> !dq_oe_o); // R12
  AST_SLEEP_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |=> ($stable(active_i) && $stable(step_i))); // R12
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_c && !sel_c) |=> !dq_oe_o); // R1
  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !strb_c && active_i && !adv_ni) |=> (step_i == $past(step_i) + 2'd1)); // R5
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !strb_c && adv_ni) |=> $stable(step_i)); // R7
endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
  .adsp_ni(adsp_ni), .adsc_ni(adsc_ni), .adv_ni(adv_ni), .oe_ni(oe_ni), .zz_i(zz_i),
  .dq_oe_o(dq_oe_o), .active_i(active), .step_i(step)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;
  localparam time TCLK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, bwe_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic oe_n = 1'b0, mode = 1'b0, zz = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #(TCLK/2) clk = ~clk;

  burst_sram u_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n), .bwe_ni(bwe_n), .bw_ni(bw_n),
    .oe_ni(oe_n), .mode_i(mode), .zz_i(zz), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  int n_chk = 0, n_fail = 0;

  // reference state from the requirements
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_start = '0, m_step = '0;
  logic          m_act = 1'b0, m_vld = 1'b0, m_mask = 1'b0;
  logic [DW-1:0] m_rd = '0;

  function automatic logic [DW-1:0] pat(int a);
    return {8'hC3 ^ 8'(a), 8'(a * 3), 8'h5A ^ 8'(a), 8'(a + 17)};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic proc, ctrl, strb, sel, acc;
    logic [1:0] nstep, lo;
    logic [AW-1:0] a;
    logic [NB-1:0] we;
    proc  = !zz && !adsp_n && !ce1_n;
    ctrl  = !zz && !adsc_n && !proc;
    strb  = proc || ctrl;
    sel   = !ce1_n && ce2 && !ce3_n;
    nstep = m_step + {1'b0, !adv_n};
    lo    = mode ? (m_start ^ nstep) : (m_start + nstep);
    a     = (strb && sel) ? addr : {m_base, lo};
    acc   = !zz && (strb ? sel : m_act);
    we    = (acc && !proc && !bwe_n) ? ~bw_n : '0;
    if (acc) m_rd = m_mem[a];
    for (int i = 0; i < NB; i++) if (we[i]) m_mem[a][i*8 +: 8] = dq_in[i*8 +: 8];
    m_mask = acc && (we == '0) && !m_act;
    m_vld  = acc && (we == '0);
    if (!zz) begin
      if (strb && sel) begin
        m_base = addr[AW-1:2]; m_start = addr[1:0]; m_step = '0; m_act = 1'b1;
      end else if (strb) m_act = 1'b0;
      else if (m_act) m_step = nstep;
    end
  endtask

  // one clock: inputs already set; compare outputs after the edge
  task automatic tick(string tag);
    logic exp_oe;
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
    exp_oe = m_vld && !m_mask && !oe_n;
    chk(tag, DW'(dq_oe), DW'(exp_oe));
    if (exp_oe) chk(tag, dq_out, m_rd);
  endtask

  task automatic quiet();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; zz = 1'b0; oe_n = 1'b0;
  endtask

  task automatic strobe(bit use_p, int a);
    quiet(); addr = AW'(a);
    if (use_p) adsp_n = 1'b0; else adsc_n = 1'b0;
  endtask

  task automatic deselect();
    quiet(); adsc_n = 1'b0; ce2 = 1'b0; tick("R1");
    chk("R1 deselect drives nothing", DW'(dq_oe), '0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(TCLK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] w9;
    int seq_lin [4] = '{7, 4, 5, 5};
    int seq_ilv [3] = '{12, 15, 14};
    void'($urandom(32'h5EED_0B57));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset output enable", DW'(dq_oe), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill array with full-word writes through the controller strobe
    for (int a = 0; a < DEPTH; a++) begin
      strobe(0, a); bwe_n = 1'b0; bw_n = '0; dq_in = pat(a);
      tick("R8");
    end
    deselect();

    // linear burst from low bits 2
    strobe(1, 6); tick("R11");
    chk("R11 first beat after deselect masked", DW'(dq_oe), '0);
    for (int k = 0; k < 4; k++) begin
      quiet(); adv_n = (k == 3) ? 1'b1 : 1'b0;
      tick(k == 3 ? "R7" : "R5");
      chk(k == 3 ? "R7 hold" : "R5 linear order", dq_out, pat(seq_lin[k]));
      chk("R9 driven", DW'(dq_oe), 1);
    end
    quiet(); adv_n = 1'b0; tick("R5");
    chk("R5 linear wrap", dq_out, pat(6));

    // asynchronous output enable
    oe_n = 1'b1; #1;
    chk("R10 oe high tristates", DW'(dq_oe), '0);
    oe_n = 1'b0; #1;
    chk("R10 oe low drives", DW'(dq_oe), 1);

    // processor strobe with ce1 high is ignored
    quiet(); ce1_n = 1'b1; adsp_n = 1'b0; addr = AW'(40); tick("R2");
    chk("R2 burst continues", dq_out, pat(6));
    chk("R2 still driven", DW'(dq_oe), 1);
    deselect();

    // both strobes with write request: read wins
    strobe(1, 9); adsc_n = 1'b0; bwe_n = 1'b0; bw_n = '0; dq_in = 32'hDEAD_BEEF;
    tick("R3");
    quiet(); tick("R3");
    chk("R3 processor strobe reads, no write", dq_out, pat(9));

    // lane writes 0 and 2
    strobe(0, 9); bwe_n = 1'b0; bw_n = 4'b1010; dq_in = 32'h1122_3344; tick("R8");
    chk("R8 write cycle not driven", DW'(dq_oe), '0);
    w9 = pat(9); w9[23:16] = 8'h22; w9[7:0] = 8'h44;
    quiet(); tick("R8");
    chk("R8 lane write", dq_out, w9);
    strobe(0, 9); bw_n = '0; dq_in = '1; tick("R8");
    chk("R8 bwe high no write", dq_out, w9);

    // sleep with a write strobe
    strobe(0, 9); bwe_n = 1'b0; bw_n = '0; dq_in = '0; zz = 1'b1; tick("R12");
    chk("R12 sleep not driven", DW'(dq_oe), '0);
    tick("R12");
    quiet(); tick("R12");
    chk("R12 contents kept", dq_out, w9);

    // interleaved from low bits 1: 1,0,3,2
    mode = 1'b1;
    strobe(1, 13); tick("R6");
    chk("R6 start beat", dq_out, pat(13));
    for (int k = 0; k < 3; k++) begin
      quiet(); adv_n = 1'b0; tick("R6");
      chk("R6 interleaved order", dq_out, pat(seq_ilv[k]));
    end

    // constrained random
    for (int blk = 0; blk < 6; blk++) begin
      quiet(); mode = blk[0]; tick("R4");
      for (int c = 0; c < 500; c++) begin
        int r = $urandom_range(0, 15);
        quiet();
        addr   = AW'($urandom);
        dq_in  = DW'($urandom);
        adsp_n = (r < 3) ? 1'b0 : 1'b1;
        adsc_n = (r >= 2 && r < 6) ? 1'b0 : 1'b1;
        adv_n  = $urandom_range(0, 2) == 0;
        bwe_n  = $urandom_range(0, 2) != 0;
        bw_n   = NB'($urandom);
        ce1_n  = $urandom_range(0, 9) == 0;
        ce2    = $urandom_range(0, 9) != 0;
        ce3_n  = $urandom_range(0, 11) == 0;
        oe_n   = $urandom_range(0, 7) == 0;
        zz     = $urandom_range(0, 15) == 0;
        tick("R4");
      end
    end
    finish_run();
  end
endmodule